// File: doc/BRIEF.md
# Execute-Stage Operand Forwarding Control

This block decides, for the instruction now in the execute stage of a five-stage pipeline, where each of its two ALU operands must come from. An operand can come from the register file, from the result held in the memory-stage pipeline register, or from the result held in the write-back-stage pipeline register. The block compares the two source register numbers of the executing instruction with the destination register numbers of the two older instructions further down the pipe. It then produces one 2-bit mux select per operand.

The logic is purely combinational. A stage may supply a value only when it actually writes a register and that register is not register 0. A load in the memory stage has no data yet, so it is never forwarded from there. When both older stages write the same source register, the memory stage holds the newer value and is preferred. The two operand selects are worked out independently of each other.

Top module: `fwd_unit`

## Requirements
- R1: With no qualifying match for an operand, its select is 2'b00 (register-file value).
- R2: An operand's select is 2'b10 (memory-stage value) when the memory stage writes a register, that register is nonzero, it equals the operand's source register, and the memory-stage instruction is not a load.
- R3: An operand's select is 2'b01 (write-back value) when the write-back stage writes a nonzero register equal to the operand's source register, and the R2 condition for that operand is false.
- R4: A stage whose register-write flag is clear never supplies an operand, whatever its destination register.
- R5: A destination register number of 0 never causes a forward from either stage, even with the write flag set.
- R6: When the memory-stage instruction is a load (memory-read flag set), the select is never 2'b10. The write-back stage still supplies the operand if it matches; otherwise the select is 2'b00.
- R7: When both stages qualify for the same operand, the select is 2'b10.
- R8: Operand A's select (fwd_a_o) is decided from the first source register (ex_rs_i), and operand B's select (fwd_b_o) from the second (ex_rt_i). Each is decided on its own, so in one cycle the two may name different stages.
- R9: No select ever takes the value 2'b11.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ex_rs_i | input | 5 | First source register of the executing instruction |
| ex_rt_i | input | 5 | Second source register of the executing instruction |
| mem_rd_i | input | 5 | Destination register of the memory-stage instruction |
| mem_wr_en_i | input | 1 | Memory-stage instruction writes a register |
| mem_load_i | input | 1 | Memory-stage instruction reads data memory (a load) |
| wb_rd_i | input | 5 | Destination register of the write-back-stage instruction |
| wb_wr_en_i | input | 1 | Write-back-stage instruction writes a register |
| fwd_a_o | output | 2 | Select for operand A: 00 register file, 10 memory stage, 01 write-back stage |
| fwd_b_o | output | 2 | Select for operand B, same encoding |

## Verification
Two functions can fall in the same cycle: a memory-stage match and a write-back-stage match on the same source register, which the priority rule must settle. The same holds for the two operands matching different stages at once. The bench provokes the first case with back-to-back writes to one register, including register 31 and a memory-stage load that hands the operand to the write-back stage. It provokes the second by giving rs and rt distinct destinations in each stage. Each select is judged against the encoding written in the requirements, sampled half a clock after the inputs change.

// File: rtl/fwd_pkg.sv
package fwd_pkg;
    localparam int REG_AW  = 5;
    localparam int NUM_OPS = 2;

    typedef enum logic [1:0] {
        SEL_RF  = 2'b00,
        SEL_WB  = 2'b01,
        SEL_MEM = 2'b10
    } fwd_sel_e;
endpackage

// File: rtl/fwd_stage_match.sv
module fwd_stage_match #(
    parameter int AW = 5
) (
    input  logic [AW-1:0] src_i,
    input  logic [AW-1:0] dst_i,
    input  logic          wr_en_i,
    input  logic          block_i,
    output logic          hit_o
);
    localparam logic [AW-1:0] ZERO_REG = '0;

    logic hit_d;

    always_comb begin
        hit_d = 1'b0;
        if (wr_en_i && !block_i && (dst_i != ZERO_REG) && (dst_i == src_i)) begin
            hit_d = 1'b1;
        end
    end

    assign hit_o = hit_d;
endmodule

// File: rtl/fwd_operand_select.sv
module fwd_operand_select
    import fwd_pkg::*;
(
    input  logic       mem_hit_i,
    input  logic       wb_hit_i,
    output logic [1:0] sel_o
);
    fwd_sel_e sel_d;

    always_comb begin
        sel_d = SEL_RF;
        if (mem_hit_i) begin
            sel_d = SEL_MEM;
        end else if (wb_hit_i) begin
            sel_d = SEL_WB;
        end
    end

    assign sel_o = sel_d;
endmodule

// File: rtl/fwd_unit.sv
module fwd_unit
    import fwd_pkg::*;
#(
    parameter int AW = REG_AW
) (
    input  logic [AW-1:0] ex_rs_i,
    input  logic [AW-1:0] ex_rt_i,
    input  logic [AW-1:0] mem_rd_i,
    input  logic          mem_wr_en_i,
    input  logic          mem_load_i,
    input  logic [AW-1:0] wb_rd_i,
    input  logic          wb_wr_en_i,
    output logic [1:0]    fwd_a_o,
    output logic [1:0]    fwd_b_o
);
    localparam int OPS = NUM_OPS;

    logic [AW-1:0] src_d     [OPS];
    logic          mem_hit_d [OPS];
    logic          wb_hit_d  [OPS];
    logic [1:0]    sel_d     [OPS];

    assign src_d[0] = ex_rs_i;
    assign src_d[1] = ex_rt_i;

    for (genvar op = 0; op < OPS; op++) begin : g_op
        fwd_stage_match #(.AW(AW)) u_mem_match (
            .src_i   (src_d[op]),
            .dst_i   (mem_rd_i),
            .wr_en_i (mem_wr_en_i),
            .block_i (mem_load_i),
            .hit_o   (mem_hit_d[op])
        );

        fwd_stage_match #(.AW(AW)) u_wb_match (
            .src_i   (src_d[op]),
            .dst_i   (wb_rd_i),
            .wr_en_i (wb_wr_en_i),
            .block_i (1'b0),
            .hit_o   (wb_hit_d[op])
        );

        fwd_operand_select u_sel (
            .mem_hit_i (mem_hit_d[op]),
            .wb_hit_i  (wb_hit_d[op]),
            .sel_o     (sel_d[op])
        );
    end

    assign fwd_a_o = sel_d[0];
    assign fwd_b_o = sel_d[1];

    always_comb begin
        for (int op = 0; op < OPS; op++) begin
            // R9
            sel_legal_chk: assert (sel_d[op] != 2'b11)
                else $error("select %0d illegal", op);
            // R6
            load_block_chk: assert (!(mem_load_i && sel_d[op] == SEL_MEM))
                else $error("load forwarded on operand %0d", op);
            // R4
            mem_wr_gate_chk: assert (mem_wr_en_i || sel_d[op] != SEL_MEM)
                else $error("memory stage forwarded without write on %0d", op);
            // R4
            wb_wr_gate_chk: assert (wb_wr_en_i || sel_d[op] != SEL_WB)
                else $error("write-back forwarded without write on %0d", op);
            // R7
            mem_priority_chk: assert (!mem_hit_d[op] || sel_d[op] == SEL_MEM)
                else $error("memory stage not preferred on %0d", op);
            // R5
            zero_reg_chk: assert (src_d[op] != '0 || sel_d[op] == SEL_RF)
                else $error("register 0 forwarded on %0d", op);
        end
    end
endmodule

// File: tb/fwd_unit_tb.sv
module fwd_unit_tb;
    localparam int AW = 5;
    localparam time HALF = 2ns;

    typedef struct packed {
        logic [4:0] rs;
        logic [4:0] rt;
        logic [4:0] mrd;
        logic       mwr;
        logic       mld;
        logic [4:0] wrd;
        logic       wwr;
        logic [1:0] ea;
        logic [1:0] eb;
        logic [3:0] req;
    } vec_t;

    localparam int NV = 14;
    localparam vec_t VECS [NV] = '{
        '{5'd3,  5'd4,  5'd5,  1'b1, 1'b0, 5'd6,  1'b1, 2'b00, 2'b00, 4'd1},
        '{5'd5,  5'd7,  5'd5,  1'b1, 1'b0, 5'd0,  1'b0, 2'b10, 2'b00, 4'd2},
        '{5'd2,  5'd5,  5'd5,  1'b1, 1'b0, 5'd0,  1'b0, 2'b00, 2'b10, 4'd2},
        '{5'd9,  5'd1,  5'd0,  1'b0, 1'b0, 5'd9,  1'b1, 2'b01, 2'b00, 4'd3},
        '{5'd1,  5'd9,  5'd0,  1'b0, 1'b0, 5'd9,  1'b1, 2'b00, 2'b01, 4'd3},
        '{5'd5,  5'd5,  5'd5,  1'b0, 1'b0, 5'd0,  1'b0, 2'b00, 2'b00, 4'd4},
        '{5'd5,  5'd5,  5'd0,  1'b0, 1'b0, 5'd5,  1'b0, 2'b00, 2'b00, 4'd4},
        '{5'd0,  5'd0,  5'd0,  1'b1, 1'b0, 5'd0,  1'b1, 2'b00, 2'b00, 4'd5},
        '{5'd8,  5'd8,  5'd0,  1'b1, 1'b0, 5'd8,  1'b1, 2'b01, 2'b01, 4'd5},
        '{5'd1,  5'd1,  5'd1,  1'b1, 1'b0, 5'd1,  1'b1, 2'b10, 2'b10, 4'd7},
        '{5'd31, 5'd31, 5'd31, 1'b1, 1'b0, 5'd31, 1'b1, 2'b10, 2'b10, 4'd7},
        '{5'd1,  5'd2,  5'd1,  1'b1, 1'b1, 5'd1,  1'b1, 2'b01, 2'b00, 4'd6},
        '{5'd1,  5'd2,  5'd1,  1'b1, 1'b1, 5'd3,  1'b1, 2'b00, 2'b00, 4'd6},
        '{5'd4,  5'd8,  5'd4,  1'b1, 1'b0, 5'd8,  1'b1, 2'b10, 2'b01, 4'd8}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [AW-1:0] ex_rs, ex_rt, mem_rd, wb_rd;
    logic mem_wr_en, mem_load, wb_wr_en;
    logic [1:0] fwd_a, fwd_b;
    int n_checks = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #HALF clk = ~clk;

    fwd_unit u_dut (
        .ex_rs_i     (ex_rs),
        .ex_rt_i     (ex_rt),
        .mem_rd_i    (mem_rd),
        .mem_wr_en_i (mem_wr_en),
        .mem_load_i  (mem_load),
        .wb_rd_i     (wb_rd),
        .wb_wr_en_i  (wb_wr_en),
        .fwd_a_o     (fwd_a),
        .fwd_b_o     (fwd_b)
    );

    task automatic apply(input logic [4:0] rs, input logic [4:0] rt,
                         input logic [4:0] mrd, input logic mwr, input logic mld,
                         input logic [4:0] wrd, input logic wwr);
        @(posedge clk);
        ex_rs = rs; ex_rt = rt; mem_rd = mrd; mem_wr_en = mwr;
        mem_load = mld; wb_rd = wrd; wb_wr_en = wwr;
        @(negedge clk);
    endtask

    task automatic check(input string tag, input logic [1:0] ea, input logic [1:0] eb);
        n_checks++;
        if (fwd_a !== ea || fwd_b !== eb) begin
            n_fail++;
            $display("FAIL %s: a=%b b=%b expected a=%b b=%b", tag, fwd_a, fwd_b, ea, eb);
        end
    endtask

    initial begin
        ex_rs = '0; ex_rt = '0; mem_rd = '0; mem_wr_en = 1'b0;
        mem_load = 1'b0; wb_rd = '0; wb_wr_en = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R1 idle state", 2'b00, 2'b00);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            apply(VECS[i].rs, VECS[i].rt, VECS[i].mrd, VECS[i].mwr, VECS[i].mld,
                  VECS[i].wrd, VECS[i].wwr);
            check($sformatf("R%0d table row %0d", VECS[i].req, i), VECS[i].ea, VECS[i].eb);
        end

        // R2 and R5: memory-stage sweep over every register on operand A
        for (int r = 0; r < 32; r++) begin
            apply(r[4:0], 5'd0, r[4:0], 1'b1, 1'b0, 5'd0, 1'b0);
            check("R2 memory sweep", (r != 0) ? 2'b10 : 2'b00, 2'b00);
        end
        // R3 and R5: write-back sweep over every register on operand B
        for (int r = 0; r < 32; r++) begin
            apply(5'd0, r[4:0], 5'd0, 1'b0, 1'b0, r[4:0], 1'b1);
            check("R3 write-back sweep", 2'b00, (r != 0) ? 2'b01 : 2'b00);
        end
        // R7: both stages write the same register, operand A only
        apply(5'd12, 5'd13, 5'd12, 1'b1, 1'b0, 5'd12, 1'b1);
        check("R7 same-register priority", 2'b10, 2'b00);
        // R6: load in memory stage on B, write-back on A
        apply(5'd6, 5'd7, 5'd7, 1'b1, 1'b1, 5'd6, 1'b1);
        check("R6 load blocked, other operand from write-back", 2'b01, 2'b00);
        // R8: operands cross stages
        apply(5'd20, 5'd21, 5'd21, 1'b1, 1'b0, 5'd20, 1'b1);
        check("R8 crossed stages", 2'b01, 2'b10);
        // R9: no select pattern 11 observed across a busy case
        apply(5'd3, 5'd3, 5'd3, 1'b1, 1'b0, 5'd3, 1'b1);
        check("R9 legal encoding", 2'b10, 2'b10);

        done = 1'b1;
    end

    initial begin
        int cyc = 0;
        while (!done && cyc < 10000) begin
            @(posedge clk);
            cyc++;
        end
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: run did not finish, expected completion");
        end
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule